// File: doc/BRIEF.md
# Interrupt Acceptance and Exception Return Unit

This block is the processor-side decision point for interrupts. An interrupt controller presents one candidate at a time: its priority, the shadow register set it should run in, and the handler address already worked out from its vector. The unit samples that candidate once per instruction, at the point between the execute and memory stages. It takes the interrupt only when the candidate's priority is strictly above the CPU's current level and no exception is already in progress. A candidate that is refused stays pending and is looked at again at the next sample point.

Taking an interrupt does several things at once. The current program counter goes into the exception program counter. The exception-level flag is set, and this flag blocks every later interrupt until software clears it. The CPU level is raised to the interrupt's priority. The active shadow set moves to the candidate's set, and the set it replaces is kept as the previous set. A one-cycle redirect to the handler follows.

An exception-return strobe undoes the entry. It clears the flag, restores the saved CPU level, switches back to the previous shadow set, and redirects to the saved program counter. Software can write the flag and the CPU level directly. Once the flag is cleared this way, a higher-priority interrupt can nest. Hardware keeps only one saved copy of the level and the shadow set.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, all of these are zero: exl, cpu_prio, epc, active_set and prev_set. redirect is low and redirect_pc is zero.
- R2: A candidate is accepted only if irq_prio is strictly greater than cpu_prio. A candidate whose priority equals cpu_prio is not accepted and causes no state change.
- R3: While exl is 1, no candidate is accepted, whatever its priority.
- R4: On acceptance, the edge that takes it loads epc with cur_pc and sets exl to 1.
- R5: On acceptance, cpu_prio becomes irq_prio, prev_set becomes the old active_set, and active_set becomes irq_set.
- R6: One cycle after an acceptance, redirect is high for that cycle and redirect_pc equals the irq_target presented when the interrupt was accepted. In a cycle with no entry and no return before it, redirect is low and redirect_pc is zero.
- R7: When eret is high, the next state has exl at 0, cpu_prio equal to the level saved at the last entry, and active_set equal to prev_set. The next cycle also shows redirect high with redirect_pc equal to the epc value from before the return.
- R8: If eret and a qualifying candidate arrive in the same cycle, only the return is carried out. The candidate is evaluated again in the following cycle.
- R9: A software write (sw_we high) loads exl from sw_exl and cpu_prio from sw_prio. The write is ignored in any cycle where an entry or a return happens.
- R10: While sample_en is low, no candidate is accepted.
- R11: After software clears exl inside a handler, a candidate of higher priority is taken. A return from that nested handler restores cpu_prio to the outer handler's level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_en | input | 1 | Pipeline sample point (between execute and memory stages) |
| irq_valid | input | 1 | A candidate interrupt is presented |
| irq_prio | input | 3 | Candidate priority, 0 to 7 |
| irq_set | input | SET_W | Candidate shadow register set |
| irq_target | input | ADDR_W | Candidate handler address |
| cur_pc | input | ADDR_W | Program counter of the instruction at the sample point |
| eret | input | 1 | Exception-return strobe |
| sw_we | input | 1 | Software write of exl and cpu_prio |
| sw_exl | input | 1 | Value written to exl |
| sw_prio | input | 3 | Value written to cpu_prio |
| redirect | output | 1 | One-cycle fetch redirect request |
| redirect_pc | output | ADDR_W | Redirect target; zero when idle |
| exl | output | 1 | Exception-level flag |
| cpu_prio | output | 3 | Current CPU priority level |
| epc | output | ADDR_W | Exception program counter |
| active_set | output | SET_W | Active shadow register set |
| prev_set | output | SET_W | Previous shadow register set |

## Verification
Checked on every cycle:
- An entry always raises the CPU level and saves the program counter.
- A return clears the flag and swaps the shadow set back.
- Nothing is accepted while the flag is set, while eret is high, or while sample_en is low.
- The redirect is a single pulse that carries the right target.

Only the bench scenarios can show:
- The priority restored at a return is the level saved at the matching entry, including the nested case with a single saved copy.
- A candidate deferred by a return is taken one cycle later.
- Software writes take effect only when no entry or return occurs in the same cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int unsigned PRIO_W = 3;
    typedef logic [PRIO_W-1:0] prio_t;

    // Decision made for one cycle, in precedence order: return, entry, software write
    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_ENTRY  = 2'd1,
        EV_RETURN = 2'd2,
        EV_SWWR   = 2'd3
    } event_e;
endpackage

// File: rtl/exc_accept_arb.sv
module exc_accept_arb
    import exc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sample_en,
    input  logic   irq_valid,
    input  prio_t  irq_prio,
    input  logic   exl,
    input  prio_t  cpu_prio,
    input  logic   eret,
    input  logic   sw_we,
    output event_e ev
);
    logic prio_wins;
    logic qualifies;

    always_comb begin
        prio_wins = irq_prio > cpu_prio;
        qualifies = sample_en && irq_valid && !exl && prio_wins;
        if (eret) begin
            ev = EV_RETURN;
        end else if (qualifies) begin
            ev = EV_ENTRY;
        end else if (sw_we) begin
            ev = EV_SWWR;
        end else begin
            ev = EV_NONE;
        end
    end

    // R8: a return strobe always takes the cycle
    p_return_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eret |-> ev == EV_RETURN);

    // R2: an entry never happens at or below the current level
    p_strict_prio_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_ENTRY) |-> irq_prio > cpu_prio);
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
    import exc_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned SET_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  event_e            ev,
    input  prio_t             irq_prio,
    input  logic [SET_W-1:0]  irq_set,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic              sw_exl,
    input  prio_t             sw_prio,
    output logic              exl,
    output prio_t             cpu_prio,
    output logic [ADDR_W-1:0] epc,
    output logic [SET_W-1:0]  active_set,
    output logic [SET_W-1:0]  prev_set
);
    typedef struct packed {
        logic              exl;
        prio_t             prio;
        prio_t             saved_prio;
        logic [ADDR_W-1:0] epc;
        logic [SET_W-1:0]  act;
        logic [SET_W-1:0]  prev;
    } state_t;

    localparam state_t RESET_STATE = '0;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (ev)
            EV_ENTRY: begin
                s_d.exl        = 1'b1;
                s_d.epc        = cur_pc;
                s_d.saved_prio = s_q.prio;
                s_d.prio       = irq_prio;
                s_d.prev       = s_q.act;
                s_d.act        = irq_set;
            end
            EV_RETURN: begin
                s_d.exl  = 1'b0;
                s_d.prio = s_q.saved_prio;
                s_d.act  = s_q.prev;
            end
            EV_SWWR: begin
                s_d.exl  = sw_exl;
                s_d.prio = sw_prio;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= RESET_STATE;
        end else begin
            s_q <= s_d;
        end
    end

    assign exl        = s_q.exl;
    assign cpu_prio   = s_q.prio;
    assign epc        = s_q.epc;
    assign active_set = s_q.act;
    assign prev_set   = s_q.prev;

    // R4: an entry saves the program counter and raises the exception level
    p_entry_save_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_ENTRY) |=> exl && epc == $past(cur_pc));

    // R5: an entry raises the level and moves the shadow sets
    p_entry_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_ENTRY) |=> cpu_prio > $past(cpu_prio)
            && active_set == $past(irq_set) && prev_set == $past(active_set));

    // R7: a return clears the flag and reverts the shadow set
    p_return_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_RETURN) |=> !exl && active_set == $past(prev_set));

    // R9: with no event, the visible state holds
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_NONE) |=> $stable(exl) && $stable(cpu_prio) && $stable(epc)
            && $stable(active_set));
endmodule

// File: rtl/exc_redirect_gen.sv
module exc_redirect_gen
    import exc_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  event_e            ev,
    input  logic [ADDR_W-1:0] irq_target,
    input  logic [ADDR_W-1:0] epc,
    output logic              redirect,
    output logic [ADDR_W-1:0] redirect_pc
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] pc;
    } redir_t;

    redir_t r_d, r_q;

    always_comb begin
        r_d = '0;
        if (ev == EV_ENTRY) begin
            r_d.valid = 1'b1;
            r_d.pc    = irq_target;
        end else if (ev == EV_RETURN) begin
            r_d.valid = 1'b1;
            r_d.pc    = epc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign redirect    = r_q.valid;
    assign redirect_pc = r_q.pc;

    // R6: an entry is followed by one redirect to the handler
    p_entry_redirect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_ENTRY) |=> redirect && redirect_pc == $past(irq_target));

    // R7: a return is followed by a redirect to the saved program counter
    p_return_redirect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_RETURN) |=> redirect && redirect_pc == $past(epc));

    // R6: quiet cycles produce no redirect
    p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_NONE || ev == EV_SWWR) |=> !redirect && redirect_pc == '0);
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned SET_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              irq_valid,
    input  logic [2:0]        irq_prio,
    input  logic [SET_W-1:0]  irq_set,
    input  logic [ADDR_W-1:0] irq_target,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic              eret,
    input  logic              sw_we,
    input  logic              sw_exl,
    input  logic [2:0]        sw_prio,
    output logic              redirect,
    output logic [ADDR_W-1:0] redirect_pc,
    output logic              exl,
    output logic [2:0]        cpu_prio,
    output logic [ADDR_W-1:0] epc,
    output logic [SET_W-1:0]  active_set,
    output logic [SET_W-1:0]  prev_set
);
    event_e ev;

    exc_accept_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .irq_valid (irq_valid),
        .irq_prio  (irq_prio),
        .exl       (exl),
        .cpu_prio  (cpu_prio),
        .eret      (eret),
        .sw_we     (sw_we),
        .ev        (ev)
    );

    exc_state_regs #(.ADDR_W(ADDR_W), .SET_W(SET_W)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev         (ev),
        .irq_prio   (irq_prio),
        .irq_set    (irq_set),
        .cur_pc     (cur_pc),
        .sw_exl     (sw_exl),
        .sw_prio    (sw_prio),
        .exl        (exl),
        .cpu_prio   (cpu_prio),
        .epc        (epc),
        .active_set (active_set),
        .prev_set   (prev_set)
    );

    exc_redirect_gen #(.ADDR_W(ADDR_W)) u_redir (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev          (ev),
        .irq_target  (irq_target),
        .epc         (epc),
        .redirect    (redirect),
        .redirect_pc (redirect_pc)
    );

    // R3: the exception level blocks every entry
    p_exl_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        exl |=> !(redirect && $past(!eret)));

    // R10: nothing is accepted away from the sample point
    p_no_sample_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_en && !eret) |=> !redirect);
endmodule

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;
    localparam int AW = 32;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sample_en = 1'b0, irq_valid = 1'b0, eret = 1'b0;
    logic          sw_we = 1'b0, sw_exl = 1'b0;
    logic [2:0]    irq_prio = '0, sw_prio = '0;
    logic [SW-1:0] irq_set = '0;
    logic [AW-1:0] irq_target = '0, cur_pc = '0;
    logic          redirect, exl;
    logic [AW-1:0] redirect_pc, epc;
    logic [2:0]    cpu_prio;
    logic [SW-1:0] active_set, prev_set;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model state
    logic          m_exl, m_red;
    logic [2:0]    m_prio, m_saved;
    logic [AW-1:0] m_epc, m_rpc;
    logic [SW-1:0] m_act, m_prev;

    always #2.5 clk = ~clk;

    exc_entry_ctrl #(.ADDR_W(AW), .SET_W(SW)) uut (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .irq_valid(irq_valid),
        .irq_prio(irq_prio), .irq_set(irq_set), .irq_target(irq_target),
        .cur_pc(cur_pc), .eret(eret), .sw_we(sw_we), .sw_exl(sw_exl),
        .sw_prio(sw_prio), .redirect(redirect), .redirect_pc(redirect_pc),
        .exl(exl), .cpu_prio(cpu_prio), .epc(epc), .active_set(active_set),
        .prev_set(prev_set)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit accepts();
        return sample_en && irq_valid && !m_exl && (irq_prio > m_prio) && !eret;
    endfunction

    // Advance one cycle with the inputs already driven, update model, compare
    task automatic step();
        bit acc = accepts();
        @(posedge clk);
        #1;
        if (eret) begin
            m_red = 1'b1; m_rpc = m_epc;
            m_exl = 1'b0; m_prio = m_saved; m_act = m_prev;
        end else if (acc) begin
            m_red = 1'b1; m_rpc = irq_target;
            m_epc = cur_pc; m_exl = 1'b1; m_saved = m_prio;
            m_prio = irq_prio; m_prev = m_act; m_act = irq_set;
        end else begin
            m_red = 1'b0; m_rpc = '0;
            if (sw_we) begin
                m_exl = sw_exl; m_prio = sw_prio;
            end
        end
        chk("R3/R4 exl", exl, m_exl);
        chk("R5/R9 cpu_prio", cpu_prio, m_prio);
        chk("R4 epc", epc, m_epc);
        chk("R5/R7 active_set", active_set, m_act);
        chk("R5 prev_set", prev_set, m_prev);
        chk("R6/R7 redirect", redirect, m_red);
        chk("R6/R7 redirect_pc", redirect_pc, m_rpc);
        @(negedge clk);
    endtask

    task automatic idle_in();
        sample_en = 1'b0; irq_valid = 1'b0; eret = 1'b0; sw_we = 1'b0;
    endtask

    task automatic present(input logic [2:0] p, input logic [SW-1:0] s,
                           input logic [AW-1:0] tgt, input logic [AW-1:0] pc);
        sample_en = 1'b1; irq_valid = 1'b1; irq_prio = p; irq_set = s;
        irq_target = tgt; cur_pc = pc;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_exl = 0; m_red = 0; m_prio = 0; m_saved = 0; m_epc = 0; m_rpc = 0;
        m_act = 0; m_prev = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 exl", exl, 0);
        chk("R1 cpu_prio", cpu_prio, 0);
        chk("R1 epc", epc, 0);
        chk("R1 active_set", active_set, 0);
        chk("R1 prev_set", prev_set, 0);
        chk("R1 redirect", redirect, 0);
        chk("R1 redirect_pc", redirect_pc, 0);

        // R9: software write of level
        idle_in(); sw_we = 1; sw_exl = 0; sw_prio = 3'd2; step();
        chk("R9 sw prio", cpu_prio, 2);

        // R2: equal priority refused
        idle_in(); present(3'd2, 3'd1, 32'h4000, 32'h80); step();
        chk("R2 equal not taken", redirect, 0);
        chk("R2 exl unchanged", exl, 0);

        // R10: no sample point
        idle_in(); present(3'd5, 3'd3, 32'h8000, 32'h100); sample_en = 0; step();
        chk("R10 not sampled", redirect, 0);

        // R4/R5/R6: accept
        idle_in(); present(3'd5, 3'd3, 32'h8000, 32'h100); step();
        chk("R6 redirect", redirect, 1);
        chk("R6 target", redirect_pc, 32'h8000);
        chk("R4 epc", epc, 32'h100);
        chk("R4 exl", exl, 1);
        chk("R5 prio", cpu_prio, 5);
        chk("R5 active", active_set, 3);
        chk("R5 prev", prev_set, 0);
        idle_in(); step();
        chk("R6 single pulse", redirect, 0);

        // R3: exl blocks higher priority
        idle_in(); present(3'd7, 3'd6, 32'h9999, 32'h300); step();
        chk("R3 blocked", redirect, 0);
        chk("R3 epc kept", epc, 32'h100);

        // R11: software clears exl, nested entry
        idle_in(); sw_we = 1; sw_exl = 0; sw_prio = 3'd5; step();
        idle_in(); present(3'd6, 3'd5, 32'h9000, 32'h200); step();
        chk("R11 nested taken", redirect, 1);
        chk("R11 nested prio", cpu_prio, 6);
        chk("R11 nested prev", prev_set, 3);

        // R8 + R7: return with qualifying candidate in same cycle
        idle_in(); present(3'd7, 3'd2, 32'hA000, 32'h500); eret = 1; step();
        chk("R8 return done", redirect_pc, 32'h200);
        chk("R7 exl cleared", exl, 0);
        chk("R11 prio restored to outer", cpu_prio, 5);
        chk("R7 set reverted", active_set, 3);
        eret = 0; step();
        chk("R8 deferred taken", redirect_pc, 32'hA000);
        chk("R8 deferred epc", epc, 32'h500);

        // R9: software write ignored when entry happens
        idle_in(); eret = 1; step();
        idle_in(); present(3'd6, 3'd1, 32'hB000, 32'h600);
        sw_we = 1; sw_exl = 0; sw_prio = 3'd1; step();
        chk("R9 write ignored exl", exl, 1);
        chk("R9 write ignored prio", cpu_prio, 6);
        idle_in(); sw_we = 1; sw_exl = 1; sw_prio = 3'd0; eret = 1; step();
        chk("R9 write ignored on return", exl, 0);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            sample_en  = ($urandom % 10) < 7;
            irq_valid  = ($urandom % 10) < 6;
            irq_prio   = 3'($urandom);
            irq_set    = SW'($urandom);
            irq_target = $urandom & 32'hFFFF_FFFC;
            cur_pc     = $urandom & 32'hFFFF_FFFC;
            eret       = ($urandom % 10) == 0;
            sw_we      = ($urandom % 100) < 15;
            sw_exl     = ($urandom % 4) == 0;
            sw_prio    = 3'($urandom);
            step();
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule